// File: doc/BRIEF.md
# Biphase-mark audio subframe transmitter

This block turns a stream of stereo sample pairs into a single self-clocking serial line. Each sample pair becomes one frame, sent as two 32-slot subframes: the first channel, then the second. Every subframe opens with an eight-cell sync pattern. The remaining 28 slots carry the audio word, a validity flag, a user bit, one channel-status bit and an even-parity bit, all biphase-mark coded. A frame counter marks the start of each 192-frame block with its own sync pattern and steps through a 192-bit channel-status vector, one bit per frame.

The block runs from one clock and one enable pulse per half-bit cell. It takes samples through a valid/ready handshake into a one-deep holding register, and that register is emptied once per frame, on the first cell of the frame. If no sample is waiting, the frame is filled with silence marked unreliable. Each sync pattern is sent with its polarity chosen so that its first cell is always a transition from the level left by the preceding cell.

Top module: `pcm_biphase_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `line_out` is 0 and `s_ready` is 1. The first subframe sent after reset is a block-start subframe.
- R2: A subframe spans 64 enabled cells. Cells 0..7 carry a sync pattern, sent first bit first: X = 11100010, Y = 11100100, Z = 11101000. Slot k (4..31) occupies cells 2k and 2k+1.
- R3: The first-channel subframe of frame 0 of each 192-frame block uses Z. Every other first-channel subframe uses X. Every second-channel subframe uses Y. The first channel is always sent before the second.
- R4: The sync cells equal the pattern XOR the line level of the cell just before cell 0. The first sync cell is therefore always a transition.
- R5: In slots 4..31 the level toggles on the first cell of each slot, and toggles on the second cell only when the slot's bit is 1.
- R6: The audio sample lies in slots 4..27 with its MSB in slot 27. A sample narrower than 24 bits (parameter `AUDIO_W`) fills the top slots, and the lower slots are 0.
- R7: Slot 28 carries that channel's validity input, slot 29 its user input, and slot 30 `cs_bits[f]`, where f is the frame number within the block. Both subframes of a frame carry the same status bit.
- R8: Slot 31 makes the number of ones across slots 4..31 even.
- R9: `s_ready` is high exactly while the holding register is empty. At most one sample is taken per frame, and it is taken on the first cell of the frame.
- R10: A sample accepted in the same cycle as the first cell of a frame, while the holding register is empty, is carried by that frame.
- R11: A frame that starts with no sample available carries audio 0, validity 1 and user 0 in both subframes.
- R12: In a cycle with `cell_en` low, `line_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | One pulse per half-bit cell; advances the line by one cell |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty; sample accepted when s_valid is also high |
| s_left | input | AUDIO_W | First-channel sample, two's complement |
| s_right | input | AUDIO_W | Second-channel sample, two's complement |
| s_vld_l | input | 1 | Validity bit for the first channel |
| s_vld_r | input | 1 | Validity bit for the second channel |
| s_usr_l | input | 1 | User bit for the first channel |
| s_usr_r | input | 1 | User bit for the second channel |
| cs_bits | input | 192 | Channel-status vector; bit f goes out in frame f of the block |
| line_out | output | 1 | Biphase-mark line level, one value per cell |

## Verification
Two functions can land in the same cycle: a handshake acceptance and the frame-start take that empties the holding register. The bench withholds samples for two frames, which forces silent frames. It then raises `s_valid` exactly in the cycle that issues the frame's first cell. It judges the result by decoding that frame from the line and expecting the newly offered sample, not silence and not a one-frame delay. A second collision, block wrap against the start of a first-channel subframe, is judged from the sync pattern decoded at frames 0, 192 and 384.

// File: rtl/bmtx_pkg.sv
package bmtx_pkg;
  localparam int SLOTS      = 32;
  localparam int CELLS      = 2 * SLOTS;
  localparam int CELL_W     = $clog2(CELLS);
  localparam int PRE_CELLS  = 8;
  localparam int AUD_BITS   = 24;
  localparam int FIELD_LO   = 4;
  localparam int PAYLOAD_W  = SLOTS - FIELD_LO;

  typedef enum logic [1:0] {
    PRE_X = 2'd0,
    PRE_Y = 2'd1,
    PRE_Z = 2'd2
  } pre_kind_e;

  typedef struct packed {
    logic [AUD_BITS-1:0] aud_a;
    logic [AUD_BITS-1:0] aud_b;
    logic                vld_a;
    logic                vld_b;
    logic                usr_a;
    logic                usr_b;
  } frame_t;

  localparam frame_t IDLE_FRAME = '{aud_a: '0, aud_b: '0,
                                    vld_a: 1'b1, vld_b: 1'b1,
                                    usr_a: 1'b0, usr_b: 1'b0};

  function automatic logic [PRE_CELLS-1:0] pre_pattern(input pre_kind_e k);
    case (k)
      PRE_Y:   return 8'b1110_0100;
      PRE_Z:   return 8'b1110_1000;
      default: return 8'b1110_0010;
    endcase
  endfunction
endpackage

// File: rtl/bmtx_sample_buf.sv
module bmtx_sample_buf
  import bmtx_pkg::*;
#(
  parameter int AUDIO_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [AUDIO_W-1:0] s_left,
  input  logic [AUDIO_W-1:0] s_right,
  input  logic               s_vld_l,
  input  logic               s_vld_r,
  input  logic               s_usr_l,
  input  logic               s_usr_r,
  input  logic               take,
  output frame_t             take_data
);
  localparam int PAD = AUD_BITS - AUDIO_W;

  function automatic logic [AUD_BITS-1:0] align(input logic [AUDIO_W-1:0] x);
    return AUD_BITS'(x) << PAD;
  endfunction

  logic   full;
  frame_t held;
  frame_t incoming;
  logic   accept;

  always_comb begin
    incoming.aud_a = align(s_left);
    incoming.aud_b = align(s_right);
    incoming.vld_a = s_vld_l;
    incoming.vld_b = s_vld_r;
    incoming.usr_a = s_usr_l;
    incoming.usr_b = s_usr_r;
  end

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;

  // a frame start either drains the held sample or takes the one arriving now
  always_comb begin
    if (full)         take_data = held;
    else if (s_valid) take_data = incoming;
    else              take_data = IDLE_FRAME;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      held <= IDLE_FRAME;
    end else if (take) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      held <= incoming;
    end
  end
endmodule

// File: rtl/bmtx_frame_seq.sv
module bmtx_frame_seq
  import bmtx_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int FW     = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_en,
  output logic [CELL_W-1:0] cell_idx,
  output logic              sub_sel,
  output logic [FW-1:0]     frame_idx,
  output pre_kind_e         pre_kind,
  output logic              take
);
  localparam logic [CELL_W-1:0] LAST_CELL  = CELL_W'(CELLS - 1);
  localparam logic [FW-1:0]     LAST_FRAME = FW'(FRAMES - 1);

  assign take = cell_en && (cell_idx == '0) && !sub_sel;

  always_comb begin
    if (sub_sel)              pre_kind = PRE_Y;
    else if (frame_idx == '0) pre_kind = PRE_Z;
    else                      pre_kind = PRE_X;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_idx  <= '0;
      sub_sel   <= 1'b0;
      frame_idx <= '0;
    end else if (cell_en) begin
      if (cell_idx == LAST_CELL) begin
        cell_idx <= '0;
        sub_sel  <= ~sub_sel;
        if (sub_sel)
          frame_idx <= (frame_idx == LAST_FRAME) ? '0 : frame_idx + 1'b1;
      end else begin
        cell_idx <= cell_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bmtx_subframe_fmt.sv
module bmtx_subframe_fmt
  import bmtx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  frame_t               take_data,
  input  logic                 sub_sel,
  input  logic                 cs_bit,
  output logic [PAYLOAD_W-1:0] payload
);
  frame_t              active;
  logic [AUD_BITS-1:0] aud;
  logic                vld;
  logic                usr;
  logic [PAYLOAD_W-2:0] body;

  always_ff @(posedge clk) begin
    if (rst)       active <= IDLE_FRAME;
    else if (take) active <= take_data;
  end

  always_comb begin
    aud  = sub_sel ? active.aud_b : active.aud_a;
    vld  = sub_sel ? active.vld_b : active.vld_a;
    usr  = sub_sel ? active.usr_b : active.usr_a;
    body = {cs_bit, usr, vld, aud};
    payload = {^body, body};
  end
endmodule

// File: rtl/bmtx_line_enc.sv
module bmtx_line_enc
  import bmtx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cell_en,
  input  logic [CELL_W-1:0]    cell_idx,
  input  pre_kind_e            pre_kind,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 line_out
);
  logic                    lvl;
  logic                    inv;
  logic                    in_pre;
  logic [PRE_CELLS-1:0]    pat;
  logic                    pat_bit;
  logic                    pol;
  logic [CELL_W-2:0]       slot;
  logic [CELL_W-2:0]       fld;
  logic                    dbit;

  always_comb begin
    in_pre  = cell_idx < CELL_W'(PRE_CELLS);
    pat     = pre_pattern(pre_kind);
    pat_bit = pat[3'd7 - cell_idx[2:0]];
    pol     = (cell_idx == '0) ? lvl : inv;
    slot    = cell_idx[CELL_W-1:1];
    fld     = slot - (CELL_W-1)'(FIELD_LO);
    dbit    = payload[fld];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0;
      inv <= 1'b0;
    end else if (cell_en) begin
      if (in_pre) begin
        lvl <= pat_bit ^ pol;
        if (cell_idx == '0) inv <= lvl;
      end else if (!cell_idx[0]) begin
        lvl <= ~lvl;
      end else begin
        lvl <= lvl ^ dbit;
      end
    end
  end

  assign line_out = lvl;
endmodule

// File: rtl/pcm_biphase_tx.sv
module pcm_biphase_tx
  import bmtx_pkg::*;
#(
  parameter int AUDIO_W = 24,
  parameter int FRAMES  = 192
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cell_en,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [AUDIO_W-1:0] s_left,
  input  logic [AUDIO_W-1:0] s_right,
  input  logic               s_vld_l,
  input  logic               s_vld_r,
  input  logic               s_usr_l,
  input  logic               s_usr_r,
  input  logic [FRAMES-1:0]  cs_bits,
  output logic               line_out
);
  localparam int FW = $clog2(FRAMES);

  logic [CELL_W-1:0]    cell_idx;
  logic                 sub_sel;
  logic [FW-1:0]        frame_idx;
  pre_kind_e            pre_kind;
  logic                 take;
  frame_t               take_data;
  logic [PAYLOAD_W-1:0] payload;
  logic                 cs_bit;

  assign cs_bit = cs_bits[frame_idx];

  bmtx_sample_buf #(.AUDIO_W(AUDIO_W)) u_buf (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .s_vld_l(s_vld_l), .s_vld_r(s_vld_r),
    .s_usr_l(s_usr_l), .s_usr_r(s_usr_r), .take(take), .take_data(take_data)
  );

  bmtx_frame_seq #(.FRAMES(FRAMES), .FW(FW)) u_seq (
    .clk(clk), .rst(rst), .cell_en(cell_en), .cell_idx(cell_idx),
    .sub_sel(sub_sel), .frame_idx(frame_idx), .pre_kind(pre_kind), .take(take)
  );

  bmtx_subframe_fmt u_fmt (
    .clk(clk), .rst(rst), .take(take), .take_data(take_data),
    .sub_sel(sub_sel), .cs_bit(cs_bit), .payload(payload)
  );

  bmtx_line_enc u_enc (
    .clk(clk), .rst(rst), .cell_en(cell_en), .cell_idx(cell_idx),
    .pre_kind(pre_kind), .payload(payload), .line_out(line_out)
  );
endmodule

// File: rtl/pcm_biphase_tx_chk.sv
module pcm_biphase_tx_chk
  import bmtx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cell_en,
  input logic              s_valid,
  input logic              s_ready,
  input logic              line_out,
  input logic [CELL_W-1:0] cell_idx,
  input logic              take
);
  // R12: idle cycles leave the line untouched
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !cell_en |=> $stable(line_out));

  // R5: every data slot opens with a transition
  a_r5_slot_edge: assert property (@(posedge clk) disable iff (rst)
    (cell_en && cell_idx >= CELL_W'(PRE_CELLS) && !cell_idx[0])
      |=> line_out != $past(line_out));

  // R4: the first sync cell always differs from the level before it
  a_r4_sync_lead: assert property (@(posedge clk) disable iff (rst)
    (cell_en && cell_idx == '0) |=> line_out != $past(line_out));

  // R9: an acceptance outside a frame start fills the holding register
  a_r9_fill: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && !take) |=> !s_ready);

  // R9: a frame start always leaves the holding register empty
  a_r9_drain: assert property (@(posedge clk) disable iff (rst)
    take |=> s_ready);
endmodule

bind pcm_biphase_tx pcm_biphase_tx_chk u_chk (
  .clk(clk), .rst(rst), .cell_en(cell_en), .s_valid(s_valid),
  .s_ready(s_ready), .line_out(line_out), .cell_idx(cell_idx), .take(take)
);

// File: tb/sim_pcm_biphase_tx.sv
`timescale 1ns/1ps
module sim_pcm_biphase_tx;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cell_en = 1'b0;
  logic         s_valid = 1'b0;
  logic [23:0]  s_left = '0, s_right = '0;
  logic         s_vld_l = 1'b0, s_vld_r = 1'b0, s_usr_l = 1'b0, s_usr_r = 1'b0;
  logic [191:0] cs_bits = '0;
  wire          s_ready, s_ready_n, line_out, line_n;

  always #2.5 clk = ~clk;

  pcm_biphase_tx u0 (
    .clk(clk), .rst(rst), .cell_en(cell_en), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .s_vld_l(s_vld_l), .s_vld_r(s_vld_r),
    .s_usr_l(s_usr_l), .s_usr_r(s_usr_r), .cs_bits(cs_bits), .line_out(line_out));

  // narrow-sample variant fed the low 16 bits
  pcm_biphase_tx #(.AUDIO_W(16)) u1 (
    .clk(clk), .rst(rst), .cell_en(cell_en), .s_valid(s_valid), .s_ready(s_ready_n),
    .s_left(s_left[15:0]), .s_right(s_right[15:0]), .s_vld_l(s_vld_l), .s_vld_r(s_vld_r),
    .s_usr_l(s_usr_l), .s_usr_r(s_usr_r), .cs_bits(cs_bits), .line_out(line_n));

  typedef struct packed {
    int unsigned cyc;
    logic [23:0] l, r;
    logic vl, vr, ul, ur;
  } smp_t;

  int   checks = 0, errors = 0;
  bit   done = 1'b0, reported = 1'b0;
  smp_t q[$];
  smp_t cur;
  int unsigned cyc = 0, t_start = 0;
  bit   pend = 1'b0, acc_flag = 1'b0;
  int   icc = 0, mcc = 0, frames_done = 0, coinc = 0, under = 0;
  logic [63:0] c0, c1;
  logic pl0 = 1'b0, pl1 = 1'b0, prev_line = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (frame %0d)", req, act, exp, frames_done);
    end
  endtask

  task automatic check_sub(input logic [63:0] c, input logic pl, input int sub, input int fr,
                           input logic [23:0] aud, input logic v, input logic u,
                           input string tag, output logic endl);
    logic [7:0]  pat, got;
    logic [31:0] w;
    bit          cod_ok;
    int          blk;
    blk = fr % 192;
    pat = (sub == 1) ? 8'b11100100 : ((blk == 0) ? 8'b11101000 : 8'b11100010);
    for (int i = 0; i < 8; i++) got[7-i] = c[i];
    check(got == (pat ^ {8{pl}}), {tag, " R1 R2 R3 R4 sync pattern"}, 32'(got), 32'(pat ^ {8{pl}}));
    w = '0;
    cod_ok = 1'b1;
    for (int s = 4; s < 32; s++) begin
      if (c[2*s] == c[2*s-1]) cod_ok = 1'b0;
      w[s] = c[2*s] ^ c[2*s+1];
    end
    check(cod_ok, {tag, " R5 slot boundary transition"}, 32'(cod_ok), 32'd1);
    check(w[27:4] == aud, {tag, " R6/R11 audio slots"}, 32'(w[27:4]), 32'(aud));
    check(w[28] == v, {tag, " R7/R11 validity slot"}, 32'(w[28]), 32'(v));
    check(w[29] == u, {tag, " R7/R11 user slot"}, 32'(w[29]), 32'(u));
    check(w[30] == cs_bits[blk], {tag, " R7 status slot"}, 32'(w[30]), 32'(cs_bits[blk]));
    check(^w[31:4] == 1'b0, {tag, " R8 even parity"}, w, 32'd0);
    endl = c[63];
  endtask

  task automatic decode_sub(input int sub);
    logic [23:0] a0;
    if (sub == 0) begin
      check(q.size() <= 2, "R9 one sample per frame", 32'(q.size()), 32'd2);
      if (q.size() > 0 && q[0].cyc <= t_start) begin
        cur = q.pop_front();
        if (cur.cyc == t_start) coinc++;
      end else begin
        cur = '{cyc: 0, l: '0, r: '0, vl: 1'b1, vr: 1'b1, ul: 1'b0, ur: 1'b0};
        under++;
      end
    end
    a0 = (sub == 0) ? cur.l : cur.r;
    check_sub(c0, pl0, sub, frames_done, a0, (sub == 0) ? cur.vl : cur.vr,
              (sub == 0) ? cur.ul : cur.ur, "u0", pl0);
    check_sub(c1, pl1, sub, frames_done, {a0[15:0], 8'h00}, (sub == 0) ? cur.vl : cur.vr,
              (sub == 0) ? cur.ul : cur.ur, "u1", pl1);
  endtask

  // monitor: reads outputs half a cycle after each edge
  always @(negedge clk) begin
    if (rst) begin
      prev_line = line_out;
    end else if (!done) begin
      if (pend) begin
        c0[mcc % 64] = line_out;
        c1[mcc % 64] = line_n;
        mcc++;
        if (mcc == 64) decode_sub(0);
        if (mcc == 128) begin
          decode_sub(1);
          mcc = 0;
          frames_done++;
          if (frames_done == 400) done = 1'b1;
        end
      end else begin
        check(line_out == prev_line, "R12 line holds without cell_en", 32'(line_out), 32'(prev_line));
      end
      prev_line = line_out;
      acc_flag = s_valid && s_ready;
      if (acc_flag)
        q.push_back('{cyc: cyc, l: s_left, r: s_right, vl: s_vld_l, vr: s_vld_r, ul: s_usr_l, ur: s_usr_r});
      if (cell_en) begin
        if (icc == 0) t_start = cyc;
        icc = (icc + 1) % 128;
      end
      pend = cell_en;
      cyc++;
    end
  end

  function automatic logic [23:0] pick();
    case ($urandom % 8)
      0: return 24'h000000;
      1: return 24'hFFFFFF;
      2: return 24'h800001;
      default: return 24'($urandom);
    endcase
  endfunction

  // driver
  initial begin
    int  dcc, dframes, m;
    bit  en, start, offer;
    dcc = 0;
    dframes = 0;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 6; k++) cs_bits[32*k +: 32] = $urandom;
    cs_bits[0] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(line_out == 1'b0, "R1 reset line level", 32'(line_out), 32'd0);
    check(s_ready == 1'b1, "R1 reset ready", 32'(s_ready), 32'd1);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(line_out == 1'b0, "R1 line after reset", 32'(line_out), 32'd0);
    check(s_ready == 1'b1, "R1 ready after reset", 32'(s_ready), 32'd1);
    while (!done) begin
      @(posedge clk);
      #1;
      en = ($urandom % 4) != 0;
      start = en && (dcc == 0);
      if (s_valid && acc_flag) s_valid = 1'b0;
      if (!s_valid) begin
        m = dframes % 8;
        if (m >= 3 && m <= 5) offer = (m == 5) && start;
        else offer = ($urandom % 8) != 0;
        if (offer) begin
          s_left  = pick();
          s_right = pick();
          s_vld_l = 1'($urandom);
          s_vld_r = 1'($urandom);
          s_usr_l = 1'($urandom);
          s_usr_r = 1'($urandom);
          s_valid = 1'b1;
        end
      end
      cell_en = en;
      if (en) begin
        if (dcc == 0) dframes++;
        dcc = (dcc + 1) % 128;
      end
    end
    cell_en = 1'b0;
    s_valid = 1'b0;
    check(coinc > 0, "R10 sample taken in frame-start cycle", 32'(coinc), 32'd1);
    check(under > 0, "R11 silent frames seen", 32'(under), 32'd1);
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!reported) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d frames", frames_done);
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule